// File: doc/BRIEF.md
# Soft-Start and Fault Supervisor

This block sequences start-up and handles protection for a step-down switching controller. It takes digitized flags: supply power-on-reset good, enable, output under-voltage, output over-voltage, a valley over-current event, over-temperature, a flag that the internal ramp has caught up with the feedback level, and a flag that the output is inside its good window. From these it produces a digital soft-start ramp code, a switching enable, two gate override commands (all gates off, or low-side clamped on) and a power-good output.

Start-up begins when both supply-good and enable are high. The ramp code then climbs at a fixed rate that does not depend on the switching activity. If the output already holds a voltage, switching stays off until the ramp reaches the feedback level. Each fault is handled in its own way. Over-current retries soft-start and latches off after a fixed number of events. Under-voltage latches all gates off. Over-voltage latches the low-side gate on. Over-temperature suspends switching until the flag clears. Only a low enable or a low supply-good clears a latched fault. All durations are parameters counted in clock cycles.

Top module: `soft_start_supervisor`

## Requirements
- R1: During soft-start, `ramp_code` starts at 0 and rises by one every STEP_CYC clock cycles until it is all ones, then holds. Outside soft-start and run, it reads 0.
- R2: During soft-start, `sw_en` stays low and `gate_off_all` stays high until `ramp_hit` has been seen high once. After that, switching stays enabled even if `ramp_hit` falls.
- R3: `uv_flag` has no effect until ARM_DLY cycles after soft-start begins.
- R4: Once armed, `uv_flag` high for UV_FILT consecutive cycles latches all gates off (`gate_off_all`=1, `sw_en`=0). A shorter pulse has no effect and restarts the filter.
- R5: `ov_flag` high for OV_FILT consecutive cycles, during soft-start or run, latches `low_clamp`=1 with `sw_en`=0 and `gate_off_all`=0. The clamp stays on after the flag falls.
- R6: `pgood` = `sw_en` AND armed (ARM_DLY cycles after soft-start begins) AND `pg_win` AND NOT `uv_flag` AND NOT `ov_flag`. It drops in the same cycle that either fault flag rises.
- R7: `en` or `por_ok` low forces shutdown in the next cycle (`gate_off_all`=1, `low_clamp`=0, `pgood`=0, `ramp_code`=0). This is the only way out of a latched fault. Raising both again starts a fresh soft-start.
- R8: Each `oc_evt` pulse during soft-start or run restarts soft-start with `ramp_code` back at 0. The OC_LIMIT-th counted pulse latches all gates off.
- R9: The over-current count is cleared only by shutdown. A successful retry does not clear it.
- R10: `ot_flag` during soft-start or run suspends switching (`gate_off_all`=1, `pgood`=0). When the flag clears, a fresh soft-start begins, with no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supply power-on-reset good |
| en | input | 1 | Enable |
| uv_flag | input | 1 | Output under-voltage comparator flag |
| ov_flag | input | 1 | Output over-voltage comparator flag |
| oc_evt | input | 1 | Valley over-current event, one cycle per event |
| ot_flag | input | 1 | Over-temperature flag |
| ramp_hit | input | 1 | Ramp has reached the feedback level |
| pg_win | input | 1 | Output inside the power-good window |
| ramp_code | output | RAMP_W | Soft-start ramp code |
| sw_en | output | 1 | Switching enable |
| gate_off_all | output | 1 | Force both gates off |
| low_clamp | output | 1 | Force low-side on, high-side off |
| pgood | output | 1 | Power-good |

## Verification
The assertions check four things on every cycle. Shutdown follows a low enable or supply-good. The low-side clamp excludes the other gate commands and holds while enabled. The ramp only steps up by one or returns to zero. Power-good never coexists with a raised fault flag. Other behaviour can only be shown by the bench's scenarios, which sweep pulse lengths and elapsed cycles against expected values worked out by arithmetic. These cover the exact ramp value at each cycle, the cycle at which arming happens, the exact filter lengths at which under- and over-voltage trip, the fourth over-current latch and the clearing of its count, pre-biased start, and suspend with recovery.

// File: rtl/soft_start_supervisor.sv
module soft_start_supervisor #(
  parameter int RAMP_W   = 8,
  parameter int STEP_CYC = 4,
  parameter int ARM_DLY  = 25000,
  parameter int UV_FILT  = 300,
  parameter int OV_FILT  = 20,
  parameter int OC_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_ok,
  input  logic              en,
  input  logic              uv_flag,
  input  logic              ov_flag,
  input  logic              oc_evt,
  input  logic              ot_flag,
  input  logic              ramp_hit,
  input  logic              pg_win,
  output logic [RAMP_W-1:0] ramp_code,
  output logic              sw_en,
  output logic              gate_off_all,
  output logic              low_clamp,
  output logic              pgood
);
  localparam int STEP_W = $clog2(STEP_CYC + 1);
  localparam int DLY_W  = $clog2(ARM_DLY + 1);
  localparam int UVF_W  = $clog2(UV_FILT + 1);
  localparam int OVF_W  = $clog2(OV_FILT + 1);
  localparam int OC_W   = $clog2(OC_LIMIT + 1);
  localparam logic [RAMP_W-1:0] RAMP_MAX  = {RAMP_W{1'b1}};
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CYC - 1);
  localparam logic [DLY_W-1:0]  ARM_LAST  = DLY_W'(ARM_DLY);
  localparam logic [UVF_W-1:0]  UV_LAST   = UVF_W'(UV_FILT - 1);
  localparam logic [OVF_W-1:0]  OV_LAST   = OVF_W'(OV_FILT - 1);
  localparam logic [OC_W-1:0]   OC_LAST   = OC_W'(OC_LIMIT - 1);

  typedef enum logic [2:0] {ST_OFF, ST_RAMP, ST_RUN, ST_SUSP, ST_TRIP, ST_CLAMP} st_t;
  st_t st, st_nx;

  logic [RAMP_W-1:0] ramp;
  logic [STEP_W-1:0] step_cnt;
  logic [DLY_W-1:0]  dly_cnt;
  logic [UVF_W-1:0]  uv_cnt;
  logic [OVF_W-1:0]  ov_cnt;
  logic [OC_W-1:0]   oc_cnt;
  logic              synced;

  wire go       = por_ok & en;
  wire active   = (st == ST_RAMP) | (st == ST_RUN);
  wire armed    = dly_cnt == ARM_LAST;
  wire uv_trip  = active & armed & uv_flag & (uv_cnt == UV_LAST);
  wire ov_trip  = active & ov_flag & (ov_cnt == OV_LAST);
  wire oc_hit   = active & oc_evt;
  wire oc_final = oc_hit & (oc_cnt == OC_LAST);

  always_comb begin
    st_nx = st;
    if (!go) st_nx = ST_OFF;
    else begin
      case (st)
        ST_OFF: st_nx = ST_RAMP;
        ST_RAMP, ST_RUN: begin
          if (ov_trip)                            st_nx = ST_CLAMP;
          else if (uv_trip)                       st_nx = ST_TRIP;
          else if (oc_hit)                        st_nx = oc_final ? ST_TRIP : ST_RAMP;
          else if (ot_flag)                       st_nx = ST_SUSP;
          else if (st == ST_RAMP && ramp == RAMP_MAX) st_nx = ST_RUN;
        end
        ST_SUSP: if (!ot_flag) st_nx = ST_RAMP;
        default: st_nx = st;
      endcase
    end
  end

  wire fresh = (st_nx == ST_RAMP) & ((st != ST_RAMP) | oc_hit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= ST_OFF;
    else        st <= st_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp     <= '0;
      step_cnt <= '0;
      dly_cnt  <= '0;
      synced   <= 1'b0;
    end else if (fresh) begin
      ramp     <= '0;
      step_cnt <= '0;
      dly_cnt  <= '0;
      synced   <= 1'b0;
    end else begin
      if (st == ST_RAMP && ramp != RAMP_MAX) begin
        if (step_cnt == STEP_LAST) begin
          step_cnt <= '0;
          ramp     <= ramp + 1'b1;
        end else begin
          step_cnt <= step_cnt + 1'b1;
        end
      end
      if (active && !armed) dly_cnt <= dly_cnt + 1'b1;
      if (active && ramp_hit) synced <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_cnt <= '0;
      ov_cnt <= '0;
    end else begin
      if (active && armed && uv_flag) uv_cnt <= (uv_cnt == UV_LAST) ? uv_cnt : uv_cnt + 1'b1;
      else                            uv_cnt <= '0;
      if (active && ov_flag) ov_cnt <= (ov_cnt == OV_LAST) ? ov_cnt : ov_cnt + 1'b1;
      else                   ov_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    oc_cnt <= '0;
    else if (!go)                                  oc_cnt <= '0;
    else if (oc_hit && !oc_final && !ov_trip && !uv_trip) oc_cnt <= oc_cnt + 1'b1;
  end

  assign ramp_code    = active ? ramp : '0;
  assign sw_en        = active & (synced | ramp_hit);
  assign low_clamp    = st == ST_CLAMP;
  assign gate_off_all = (st != ST_CLAMP) & ~sw_en;
  assign pgood        = sw_en & armed & pg_win & ~uv_flag & ~ov_flag;
endmodule

// File: rtl/soft_start_supervisor_sva.sv
module soft_start_supervisor_sva #(
  parameter int RAMP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_ok,
  input logic              en,
  input logic              uv_flag,
  input logic              ov_flag,
  input logic [RAMP_W-1:0] ramp_code,
  input logic              sw_en,
  input logic              gate_off_all,
  input logic              low_clamp,
  input logic              pgood
);
  a_r7_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_ok || !en) |=> (gate_off_all && !low_clamp && !pgood && ramp_code == '0));

  a_r5_clamp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (low_clamp && por_ok && en) |=> low_clamp);

  a_r5_clamp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    low_clamp |-> (!sw_en && !gate_off_all));

  a_r1_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ramp_code == $past(ramp_code) ||
              ramp_code == RAMP_W'($past(ramp_code) + 1'b1) ||
              ramp_code == '0));

  a_r6_pg_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (!uv_flag && !ov_flag && !gate_off_all));
endmodule

bind soft_start_supervisor soft_start_supervisor_sva #(.RAMP_W(RAMP_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en(en), .uv_flag(uv_flag),
  .ov_flag(ov_flag), .ramp_code(ramp_code), .sw_en(sw_en),
  .gate_off_all(gate_off_all), .low_clamp(low_clamp), .pgood(pgood)
);

// File: tb/soft_start_supervisor_bench.sv
module soft_start_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 4, STEP = 2, ARM = 20, UVF = 4, OVF = 3, OCL = 4;
  localparam int RMAX = (1 << RW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic por_ok = 1'b1, en = 1'b0, uv = 1'b0, ov = 1'b0, oc = 1'b0, ot = 1'b0;
  logic hit = 1'b1, win = 1'b1;
  logic [RW-1:0] ramp_code;
  logic sw_en, gate_off_all, low_clamp, pgood;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  soft_start_supervisor #(.RAMP_W(RW), .STEP_CYC(STEP), .ARM_DLY(ARM),
    .UV_FILT(UVF), .OV_FILT(OVF), .OC_LIMIT(OCL)) u_soft_start_supervisor (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en(en), .uv_flag(uv),
    .ov_flag(ov), .oc_evt(oc), .ot_flag(ot), .ramp_hit(hit), .pg_win(win),
    .ramp_code(ramp_code), .sw_en(sw_en), .gate_off_all(gate_off_all),
    .low_clamp(low_clamp), .pgood(pgood));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic restart();
    en = 1'b0; tick(1);
    en = 1'b1; tick(1);
  endtask

  task automatic oc_series(input string tag);
    for (int k = 1; k < OCL; k++) begin
      oc = 1'b1; tick(1); oc = 1'b0;
      chk({tag, " retry ramp"}, ramp_code, 0);
      chk({tag, " retry sw_en"}, sw_en, 1);
      tick(6);
      chk({tag, " retry ramp climbs"}, ramp_code, 3);
    end
    oc = 1'b1; tick(1); oc = 1'b0;
    chk({tag, " limit gate_off_all"}, gate_off_all, 1);
    chk({tag, " limit sw_en"}, sw_en, 0);
    tick(5);
    chk({tag, " limit latched"}, gate_off_all, 1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1; tick(1);
    chk("R7 reset gate_off_all", gate_off_all, 1);
    chk("R7 reset sw_en", sw_en, 0);
    chk("R7 reset pgood", pgood, 0);
    chk("R1 reset ramp", ramp_code, 0);

    en = 1'b1; tick(1);
    for (int m = 0; m <= 34; m++) begin
      chk("R1 ramp value", ramp_code, (m / STEP > RMAX) ? RMAX : m / STEP);
      chk("R6 pgood arming", pgood, (m >= ARM) ? 1 : 0);
      chk("R2 sw_en no prebias", sw_en, 1);
      tick(1);
    end

    for (int l = 1; l < UVF; l++) begin
      uv = 1'b1; tick(l);
      chk("R6 pgood drops on uv", pgood, 0);
      chk("R4 short uv sw_en", sw_en, 1);
      uv = 1'b0; tick(1);
      chk("R4 short uv no trip", sw_en, 1);
      chk("R6 pgood returns", pgood, 1);
    end
    uv = 1'b1; tick(UVF - 1);
    chk("R4 uv before filter end", sw_en, 1);
    tick(1);
    chk("R4 uv trip gate_off_all", gate_off_all, 1);
    chk("R4 uv trip sw_en", sw_en, 0);
    uv = 1'b0; tick(5);
    chk("R7 uv trip latched", gate_off_all, 1);

    en = 1'b0; tick(1);
    chk("R7 en low ramp", ramp_code, 0);
    chk("R7 en low pgood", pgood, 0);
    en = 1'b1; tick(1);
    chk("R7 restart sw_en", sw_en, 1);
    chk("R7 restart ramp", ramp_code, 0);

    uv = 1'b1; tick(10);
    chk("R3 uv ignored before arm", sw_en, 1);
    chk("R3 uv ignored gate", gate_off_all, 0);
    uv = 1'b0; tick(5);
    chk("R3 still running", sw_en, 1);

    for (int l = 1; l < OVF; l++) begin
      ov = 1'b1; tick(l);
      chk("R5 short ov no clamp", low_clamp, 0);
      ov = 1'b0; tick(1);
      chk("R5 short ov sw_en", sw_en, 1);
    end
    ov = 1'b1; tick(OVF - 1);
    chk("R5 ov before filter end", low_clamp, 0);
    tick(1);
    chk("R5 ov clamp during soft-start", low_clamp, 1);
    chk("R5 ov clamp gate_off_all", gate_off_all, 0);
    chk("R5 ov clamp sw_en", sw_en, 0);
    chk("R6 ov pgood", pgood, 0);
    ov = 1'b0; tick(4);
    chk("R5 clamp held", low_clamp, 1);
    por_ok = 1'b0; tick(1);
    chk("R7 por clears clamp", low_clamp, 0);
    chk("R7 por shutdown", gate_off_all, 1);
    por_ok = 1'b1; tick(1);

    en = 1'b0; tick(1);
    hit = 1'b0; en = 1'b1; tick(1);
    for (int m = 0; m < 10; m++) begin
      chk("R2 prebias sw_en", sw_en, 0);
      chk("R2 prebias gate_off_all", gate_off_all, 1);
      chk("R1 ramp runs while held", ramp_code, m / STEP);
      tick(1);
    end
    hit = 1'b1; tick(1);
    chk("R2 switching after hit", sw_en, 1);
    hit = 1'b0; tick(3);
    chk("R2 switching stays on", sw_en, 1);
    chk("R1 ramp after prebias", ramp_code, 7);
    hit = 1'b1;
    tick(20);
    chk("R1 ramp holds at max", ramp_code, RMAX);
    oc_series("R8");

    restart();
    oc_series("R9 count cleared");

    restart();
    tick(35);
    chk("R10 running pgood", pgood, 1);
    win = 1'b0; tick(1);
    chk("R6 outside window", pgood, 0);
    win = 1'b1; tick(1);
    chk("R6 inside window", pgood, 1);
    ot = 1'b1; tick(1);
    chk("R10 suspend gate_off_all", gate_off_all, 1);
    chk("R10 suspend pgood", pgood, 0);
    tick(5);
    chk("R10 suspend holds", sw_en, 0);
    ot = 1'b0; tick(1);
    chk("R10 resume ramp", ramp_code, 0);
    chk("R10 resume sw_en", sw_en, 1);
    tick(35);
    chk("R10 resume pgood", pgood, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule